// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

The sequencer produces the timing and the per-pin drive-level selection for a passive multiplexed segment LCD. A fast source clock first passes through a fixed divider to give a tick of about 1 kHz. A programmable prescaler then stretches that tick into drive steps. Each step either advances to the next common time slot or flips the drive polarity. For every common and segment pin the block emits a 2-bit code that picks one of four externally generated analog levels, V0 (ground) to V3 (full LCD voltage).

The selected levels depend on four things: the pixel bitmap, the number of commons in use, the waveform family and the bias scheme. In type A drive the polarity alternates inside each common slot, so every frame is DC-free on its own. In type B drive the polarity alternates once per frame, so DC balance takes two frames. Under 1/3 bias, dark pixels see the full voltage and clear pixels see one third of it. Under static drive a single common swings rail to rail, and each segment is driven in phase with it or against it.

Pixel data arrives as a whole bitmap on a valid/ready port that holds one pending slot. While the sequencer runs, a bitmap accepted into that slot is applied only at the next frame boundary. Until then the port deasserts ready, which back-pressures the producer. While the sequencer is disabled the port is always ready and an accepted bitmap takes effect at once.

Top module: `lcd_wave_seq`

## Requirements
- R1: With the block enabled, one drive step occurs every FIX_DIV*(presc+1) clock cycles. The first step lands on the FIX_DIV*(presc+1)-th rising edge after enable is first seen high.
- R2: The number of commons per frame, M, is mux_sel+1, clamped to N_COM. M is 1 when mux_sel is 0 or when bias_static is 1.
- R3: Type A (wave_b=0): step k selects common slot (k/2) mod M and polarity k mod 2. A frame is 2*M steps long.
- R4: Type B (wave_b=1): step k selects common slot k mod M and polarity (k/M) mod 2. A frame is M steps long, and polarity changes only when a frame ends.
- R5: Level codes are 0=V0, 1=V1, 2=V2 and 3=V3. Under 1/3 bias with polarity 0, the active common is 3 and the other in-use commons are 1. A dark segment is 0 and a clear segment is 2. With polarity 1, these become 0, 2, 3 and 1 respectively.
- R6: In static drive (M=1), common 0 is 3 at polarity 0 and 0 at polarity 1. A dark segment takes the opposite code and a clear segment takes the same code. Commons 1 and above are 0.
- R7: Bit c*N_SEG+s of the bitmap controls segment s while common c is active. A value of 1 means dark and 0 means clear. Static drive uses bits 0 to N_SEG-1.
- R8: While en is 0, every output code is 0, the step counters are held at zero and polarity is 0. A pending bitmap is discarded.
- R9: While en is 1, pix_ready is 1 only when the pending slot is empty. A bitmap accepted on edge t becomes visible after the first frame-ending edge later than t. While en is 0, pix_ready is 1 and an accepted bitmap is visible after the accepting edge.
- R10: Under 1/3 bias, commons with an index of M or above output code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears counters and blanks outputs |
| wave_b | input | 1 | 0 = type A, 1 = type B drive |
| bias_static | input | 1 | 1 forces static drive on common 0 |
| mux_sel | input | CW | Commons in use minus one |
| presc | input | PS_W | Prescaler: ticks per step minus one |
| pix_valid | input | 1 | Bitmap offered |
| pix_ready | output | 1 | Bitmap slot free |
| pix_data | input | N_COM*N_SEG | Bitmap, bit c*N_SEG+s |
| com_lvl | output | 2*N_COM | Level code of common c at bits 2c+1:2c |
| seg_lvl | output | 2*N_SEG | Level code of segment s at bits 2s+1:2s |

## Verification
A bitmap handshake can complete on the same edge that ends a frame. In that case the bitmap must wait a whole further frame, because the frame end only moves a slot that was already full. The bench provokes this on purpose in directed runs by placing the write exactly on the computed frame-ending edge, and also scatters writes at random offsets. At every cycle afterwards it compares all pins with a model that switches bitmaps only when the frame count has advanced past the count at the write edge.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {
    LV0 = 2'd0,
    LV1 = 2'd1,
    LV2 = 2'd2,
    LV3 = 2'd3
  } lcd_lvl_e;
endpackage

// File: rtl/lcd_clk_div.sv
// Fixed divider followed by a programmable prescaler; emits one-cycle step strobes (R1).
module lcd_clk_div #(
  parameter int FIX_DIV = 8192,
  parameter int PS_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PS_W-1:0] presc,
  output logic            step
);
  localparam int DW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(FIX_DIV - 1);

  logic [DW-1:0]   div_q;
  logic [PS_W-1:0] pre_q;
  logic            tick;

  assign tick = (div_q == DIV_LAST);
  assign step = en && tick && (pre_q >= presc);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      if (pre_q >= presc) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_phase_seq.sv
// Common slot and polarity sequencing for type A / type B drive (R3, R4).
module lcd_phase_seq #(
  parameter int N_COM = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic          wave_b,
  input  logic [CW-1:0] m_last,
  output logic [CW-1:0] phase,
  output logic          pol,
  output logic          frame_end
);
  logic last_slot;

  assign last_slot = (phase >= m_last);
  assign frame_end = step && last_slot && (wave_b || pol);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase <= '0;
      pol   <= 1'b0;
    end else if (step) begin
      if (!wave_b) begin
        pol <= ~pol;
        if (pol) phase <= last_slot ? '0 : phase + 1'b1;
      end else begin
        phase <= last_slot ? '0 : phase + 1'b1;
        if (last_slot) pol <= ~pol;
      end
    end
  end
endmodule

// File: rtl/lcd_level_map.sv
// Maps slot, polarity and bitmap row to per-pin level codes (R5, R6, R7, R10).
module lcd_level_map
  import lcd_pkg::*;
#(
  parameter int N_COM = 4,
  parameter int N_SEG = 8,
  parameter int CW    = 2
) (
  input  logic                   en,
  input  logic                   stat,
  input  logic                   pol,
  input  logic [CW-1:0]          phase,
  input  logic [CW-1:0]          m_last,
  input  logic [N_COM*N_SEG-1:0] pix,
  output logic [2*N_COM-1:0]     com_lvl,
  output logic [2*N_SEG-1:0]     seg_lvl
);
  logic [N_SEG-1:0] row;

  assign row = pix[int'(phase)*N_SEG +: N_SEG];

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    lcd_lvl_e lv;
    always_comb begin
      if (!en)                      lv = LV0;
      else if (stat)                lv = (c == 0) ? (pol ? LV0 : LV3) : LV0;
      else if (CW'(c) > m_last)     lv = LV0;
      else if (CW'(c) == phase)     lv = pol ? LV0 : LV3;
      else                          lv = pol ? LV2 : LV1;
    end
    assign com_lvl[2*c +: 2] = lv;
  end

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    lcd_lvl_e lv;
    always_comb begin
      if (!en)        lv = LV0;
      else if (stat)  lv = (row[s] ^ pol) ? LV0 : LV3;
      else if (row[s]) lv = pol ? LV3 : LV0;
      else            lv = pol ? LV1 : LV2;
    end
    assign seg_lvl[2*s +: 2] = lv;
  end
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq #(
  parameter int FIX_DIV = 8192,
  parameter int PS_W    = 4,
  parameter int N_COM   = 4,
  parameter int N_SEG   = 8,
  parameter int CW      = (N_COM > 1) ? $clog2(N_COM) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   wave_b,
  input  logic                   bias_static,
  input  logic [CW-1:0]          mux_sel,
  input  logic [PS_W-1:0]        presc,
  input  logic                   pix_valid,
  output logic                   pix_ready,
  input  logic [N_COM*N_SEG-1:0] pix_data,
  output logic [2*N_COM-1:0]     com_lvl,
  output logic [2*N_SEG-1:0]     seg_lvl
);
  localparam int NPIX = N_COM * N_SEG;
  localparam logic [CW-1:0] COM_MAX = CW'(N_COM - 1);

  logic            stat;
  logic [CW-1:0]   m_last;
  logic            step;
  logic [CW-1:0]   phase;
  logic            pol;
  logic            fb;
  logic [NPIX-1:0] pend_q;
  logic            pend_full;
  logic [NPIX-1:0] active;

  // R2: commons in use
  assign stat   = bias_static || (mux_sel == '0);
  assign m_last = stat ? '0 : ((mux_sel > COM_MAX) ? COM_MAX : mux_sel);

  assign pix_ready = !en || !pend_full;

  // R9: pending slot, applied at frame boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      pend_full <= 1'b0;
      active    <= '0;
    end else if (!en) begin
      pend_full <= 1'b0;
      if (pix_valid) active <= pix_data;
    end else begin
      if (fb && pend_full) begin
        active    <= pend_q;
        pend_full <= 1'b0;
      end
      if (pix_valid && pix_ready) begin
        pend_q    <= pix_data;
        pend_full <= 1'b1;
      end
    end
  end

  lcd_clk_div #(.FIX_DIV(FIX_DIV), .PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .step(step)
  );

  lcd_phase_seq #(.N_COM(N_COM), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step), .wave_b(wave_b),
    .m_last(m_last), .phase(phase), .pol(pol), .frame_end(fb)
  );

  lcd_level_map #(.N_COM(N_COM), .N_SEG(N_SEG), .CW(CW)) u_map (
    .en(en), .stat(stat), .pol(pol), .phase(phase), .m_last(m_last),
    .pix(active), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk #(
  parameter int N_COM = 4,
  parameter int N_SEG = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en,
  input logic                   wave_b,
  input logic                   pix_valid,
  input logic                   pix_ready,
  input logic                   step,
  input logic                   fb,
  input logic                   pol,
  input logic [N_COM*N_SEG-1:0] active,
  input logic [2*N_COM-1:0]     com_lvl,
  input logic [2*N_SEG-1:0]     seg_lvl
);
  p_off_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (com_lvl == '0 && seg_lvl == '0));

  p_slot_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pix_valid && pix_ready) |=> (!pix_ready || !en));

  p_hold_bitmap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fb) |=> $stable(active));

  p_pol_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wave_b && !fb) |=> $stable(pol));

  p_pol_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wave_b && step) |=> (pol != $past(pol)));

  p_no_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> $stable(pol));
endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wave_b(wave_b), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .step(step), .fb(fb), .pol(pol), .active(active),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/sim_lcd_wave_seq.sv
`timescale 1ns/1ps
module sim_lcd_wave_seq;
  localparam int D     = 4;
  localparam int PS_W  = 4;
  localparam int NC    = 4;
  localparam int NS    = 8;
  localparam int CW    = 2;
  localparam int NCYC  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, wave_b = 1'b0, bias_static = 1'b0, pix_valid = 1'b0;
  logic [CW-1:0] mux_sel = '0;
  logic [PS_W-1:0] presc = '0;
  logic pix_ready;
  logic [NC*NS-1:0] pix_data = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lcd_wave_seq #(.FIX_DIV(D), .PS_W(PS_W), .N_COM(NC), .N_SEG(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wave_b(wave_b), .bias_static(bias_static),
    .mux_sel(mux_sel), .presc(presc), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected common codes: R2, R5, R6, R10
  function automatic logic [2*NC-1:0] exp_com(input bit st, input int m, input int slot, input bit p);
    logic [2*NC-1:0] v = '0;
    for (int c = 0; c < NC; c++) begin
      logic [1:0] l;
      if (st)            l = (c == 0) ? (p ? 2'd0 : 2'd3) : 2'd0;
      else if (c >= m)   l = 2'd0;
      else if (c == slot) l = p ? 2'd0 : 2'd3;
      else               l = p ? 2'd2 : 2'd1;
      v[2*c +: 2] = l;
    end
    return v;
  endfunction

  // Expected segment codes: R5, R6, R7
  function automatic logic [2*NS-1:0] exp_seg(input bit st, input int slot, input bit p,
                                              input logic [NC*NS-1:0] bm);
    logic [2*NS-1:0] v = '0;
    for (int s = 0; s < NS; s++) begin
      logic dark;
      logic [1:0] l;
      dark = bm[slot*NS + s];
      if (st)        l = (dark ^ p) ? 2'd0 : 2'd3;
      else if (dark) l = p ? 2'd3 : 2'd0;
      else           l = p ? 2'd1 : 2'd2;
      v[2*s +: 2] = l;
    end
    return v;
  endfunction

  task automatic run(input bit wb, input bit bs, input int mx, input int ps, input int cw);
    logic [NC*NS-1:0] cur, nxt;
    int m, spf, per, kw;
    bit st;
    en = 1'b0; wave_b = wb; bias_static = bs; mux_sel = CW'(mx); presc = PS_W'(ps);
    st = bs || (mx == 0);
    m = st ? 1 : ((mx + 1 > NC) ? NC : mx + 1);
    spf = wb ? m : 2 * m;
    per = D * (ps + 1);
    cur = {$urandom, $urandom};
    nxt = {$urandom, $urandom};
    // R8/R9: disabled port takes bitmap immediately, outputs blank
    pix_data = cur; pix_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    pix_valid = 1'b0;
    chk("R8 blank com", 32'(com_lvl), 32'd0);
    chk("R8 blank seg", 32'(seg_lvl), 32'd0);
    chk("R9 ready off", 32'(pix_ready), 32'd1);
    en = 1'b1;
    kw = -1;
    for (int i = 1; i <= NCYC; i++) begin
      int k, slot, fnow;
      bit p;
      logic [NC*NS-1:0] bm;
      if (i == cw) begin pix_valid = 1'b1; pix_data = nxt; end
      @(posedge clk); @(negedge clk);
      k = i / per;                         // R1 step count
      if (i == cw) begin
        pix_valid = 1'b0;
        kw = k;
        chk("R9 backpressure", 32'(pix_ready), 32'd0);
      end
      if (wb) begin slot = k % m; p = (k / m) % 2; end       // R4
      else    begin slot = (k / 2) % m; p = k % 2; end       // R3
      fnow = k / spf;
      bm = (kw >= 0 && fnow > kw / spf) ? nxt : cur;         // R9 frame-boundary apply
      chk(st ? "R6/R2 com" : (wb ? "R4/R5/R10 com" : "R3/R5/R10 com"),
          32'(com_lvl), 32'(exp_com(st, m, st ? 0 : slot, p)));
      chk(st ? "R6/R7 seg" : "R5/R7 seg", 32'(seg_lvl), 32'(exp_seg(st, st ? 0 : slot, p, bm)));
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset com", 32'(com_lvl), 32'd0);
    chk("R8 reset seg", 32'(seg_lvl), 32'd0);
    rst_n = 1'b1;
    // Directed: write lands exactly on first frame-ending edge (R9)
    run(1'b0, 1'b0, 3, 2, D * 3 * 8);
    run(1'b1, 1'b0, 3, 2, D * 3 * 4);
    run(1'b0, 1'b0, 2, 0, D * 1 * 6);
    // Directed: static drive both types (R6), 1/2 duty (R2)
    run(1'b0, 1'b1, 3, 1, 20);
    run(1'b1, 1'b0, 0, 0, 9);
    run(1'b1, 1'b0, 1, 1, 33);
    // Constrained random
    for (int r = 0; r < 24; r++)
      run(1'($urandom), ($urandom % 4) == 0, int'($urandom % 4), int'($urandom % 3),
          5 + int'($urandom % 60));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule